// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block sits beside a processor's exception logic and decides, on every clock edge, whether the pending interrupt level presented to it should be accepted. It compares that level against the interrupt level currently held in the processor status word (PS). It also requires at least one interrupt line of that level to be both raised and enabled. When the interrupt is accepted, the block commits the saved-state registers, the new PS, the next program counter and an exception-class code on that edge, and it raises a one-cycle taken strobe.

Levels above one dispatch straight to a per-level vector and use a private pair of save registers: the saved PC and the saved PS. A level-one interrupt does not get its own vector. It is turned into a general exception whose class depends on the PS user-mode and exception-mode bits. That class is user, kernel, or double when the processor is already handling an exception. Every vector can be moved by a run-time base address when relocation is enabled. All vector addresses are parameters.

PS layout used throughout: bits [3:0] hold the current interrupt level, bit 4 is the exception-mode flag and bit 5 is the user-mode flag. Exception-class codes are: 0 none, 1 high-level interrupt, 2 user, 3 kernel, 4 double.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is low at a clock edge, all output registers clear to zero, exc_class reads 0 and taken is low.
- R2: An interrupt is accepted only when pend_level is greater than PS[3:0], is no greater than NUM_LEVELS, and the AND of that level's mask slice (level_mask bits [(L-1)*NIRQ +: NIRQ]) with intset and intenable is nonzero. Level 0 is never accepted.
- R3: taken is high in exactly the cycle after each clock edge at which the R2 condition held. Every register update for that acceptance commits on that same edge.
- R4: On acceptance at level L>1, the EPC slot of level L receives pc_cur and the EPS slot of level L receives ps_cur. ps_new becomes ps_cur with bits [3:0] set to L and bit 4 set, with all other bits kept. exc_class becomes 1.
- R5: On acceptance at level L>1 without relocation, pc_next is that level's vector. The default vector for level L is 0x40000100 + 0x20*L.
- R6: On a level-1 acceptance, exccause is loaded with 4.
- R7: On a level-1 acceptance with PS bit 4 clear, EPC slot 1 receives pc_cur and ps_new is ps_cur with bit 4 set. exc_class is 2 with pc_next 0x40000340 when PS bit 5 is 1. Otherwise exc_class is 3 with pc_next 0x40000300.
- R8: On a level-1 acceptance with PS bit 4 set, exc_class is 4 and pc_next is 0x400003C0. With a DEPC register configured (default), depc receives pc_cur and EPC slot 1 is unchanged.
- R9: With reloc_en high, pc_next equals the default vector minus 0x40000000 plus vecbase.
- R10: At an edge where no interrupt is accepted, ps_new, all EPC and EPS slots, depc, exccause, pc_next and exc_class hold their previous values.
- R11: With HAS_DEPC = 0, a double exception saves pc_cur into EPC slot 1 and depc stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_level | input | LVL_W | Highest pending interrupt level |
| ps_cur | input | 32 | Current processor status word |
| intset | input | NIRQ | Raised interrupt lines |
| intenable | input | NIRQ | Enabled interrupt lines |
| level_mask | input | NUM_LEVELS*NIRQ | Per-level line masks, level L in slice L-1 |
| pc_cur | input | 32 | Program counter to save |
| vecbase | input | 32 | Run-time vector base |
| reloc_en | input | 1 | Vector relocation enable |
| ps_new | output | 32 | Updated status word |
| epc_flat | output | NUM_LEVELS*32 | Saved PC per level, level L in slice L-1 |
| eps_flat | output | (NUM_LEVELS-1)*32 | Saved PS per level 2..N, level L in slice L-2 |
| depc | output | 32 | Saved PC for double exceptions |
| exccause | output | 6 | Exception cause |
| pc_next | output | 32 | Dispatch target |
| exc_class | output | 3 | Exception-class code |
| taken | output | 1 | Acceptance strobe |

## Verification
The assertions assume that pend_level, ps_cur and the other inputs are valid and settled at every clock edge after reset. They also assume that the current level is judged from PS bits [3:0] alone. The bench meets these assumptions by driving every input on the falling edge and holding it until the next falling edge. It keeps each directed stimulus to a single cycle followed by an idle cycle, so a stimulus never carries over into the next edge. The random phase draws PS values whose level field spans 0 to 15 and pending levels up to 8, so both the out-of-range and the below-current-level rejections are exercised.

// File: rtl/idu_pkg.sv
// Package: shared encodings for the interrupt dispatch unit.
// Assumes PS keeps the interrupt level in [3:0], exception mode in bit 4
// and user mode in bit 5.
package idu_pkg;
    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_HIGH   = 3'd1,
        CLS_USER   = 3'd2,
        CLS_KERNEL = 3'd3,
        CLS_DOUBLE = 3'd4
    } exc_class_e;

    localparam int          PS_LVL_W     = 4;
    localparam int          PS_EXCM_BIT  = 4;
    localparam int          PS_UM_BIT    = 5;
    localparam int          CAUSE_W      = 6;
    localparam logic [5:0]  CAUSE_LEVEL1 = 6'd4;
endpackage

// File: rtl/idu_gate.sv
// Module: acceptance decision for the pending interrupt level.
// Assumes level_mask holds one NIRQ-wide slice per level, level 1 lowest.
module idu_gate #(
    parameter int NUM_LEVELS = 7,
    parameter int NIRQ       = 16,
    parameter int LVL_W      = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LVL_W-1:0]           pend_level,
    input  logic [3:0]                 cur_level,
    input  logic [NIRQ-1:0]            intset,
    input  logic [NIRQ-1:0]            intenable,
    input  logic [NUM_LEVELS*NIRQ-1:0] level_mask,
    output logic                       take
);
    logic [NUM_LEVELS:0] lvl_hit;
    logic                hit_sel;
    logic                in_range;
    logic                above_cur;

    assign lvl_hit[0] = 1'b0;

    // One request-present flag per configured level.
    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_hit
        assign lvl_hit[l] = |(level_mask[(l-1)*NIRQ +: NIRQ] & intset & intenable);
    end

    // Pick the request flag of the pending level.
    always_comb begin
        hit_sel = 1'b0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (int'(pend_level) == l) hit_sel = lvl_hit[l];
        end
    end

    assign in_range  = int'(pend_level) <= NUM_LEVELS;
    assign above_cur = int'(pend_level) > int'(cur_level);
    assign take      = in_range && above_cur && hit_sel;

    // Level zero can never produce an acceptance.
    p_level0_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_level == '0) |-> !take);
endmodule

// File: rtl/idu_target.sv
// Module: default vector selection and optional relocation.
// Assumes LVL_VEC holds vectors for levels 0..7; entries 0 and 1 are unused.
module idu_target
    import idu_pkg::*;
#(
    parameter int              NUM_LEVELS = 7,
    parameter int              LVL_W      = 4,
    parameter logic [31:0]     DEF_BASE   = 32'h4000_0000,
    parameter logic [7:0][31:0] LVL_VEC   = '0,
    parameter logic [31:0]     USER_VEC   = 32'h0,
    parameter logic [31:0]     KERNEL_VEC = 32'h0,
    parameter logic [31:0]     DOUBLE_VEC = 32'h0
) (
    input  exc_class_e        cls,
    input  logic [LVL_W-1:0]  level,
    input  logic [31:0]       vecbase,
    input  logic              reloc_en,
    output logic [31:0]       target
);
    logic [31:0] dflt;

    // Choose the configured vector for the class and level.
    always_comb begin
        dflt = '0;
        unique case (cls)
            CLS_HIGH: begin
                for (int l = 2; l <= NUM_LEVELS; l++) begin
                    if (int'(level) == l) dflt = LVL_VEC[l];
                end
            end
            CLS_USER:   dflt = USER_VEC;
            CLS_KERNEL: dflt = KERNEL_VEC;
            CLS_DOUBLE: dflt = DOUBLE_VEC;
            default:    dflt = '0;
        endcase
    end

    // Shift the vector onto the run-time base when relocation is on.
    assign target = reloc_en ? (dflt - DEF_BASE + vecbase) : dflt;
endmodule

// File: rtl/idu_state.sv
// Module: saved-state and next-PC registers, written only on acceptance.
// Assumes take, cls and target are settled at each clock edge.
module idu_state
    import idu_pkg::*;
#(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = 4,
    parameter bit HAS_DEPC   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  exc_class_e                   cls,
    input  logic [LVL_W-1:0]             level,
    input  logic [31:0]                  ps_cur,
    input  logic [31:0]                  pc_cur,
    input  logic [31:0]                  target,
    output logic [31:0]                  ps_q,
    output logic [NUM_LEVELS-1:0][31:0]  epc_q,
    output logic [NUM_LEVELS-2:0][31:0]  eps_q,
    output logic [31:0]                  depc_q,
    output logic [CAUSE_W-1:0]           cause_q,
    output logic [31:0]                  pc_q,
    output exc_class_e                   cls_q,
    output logic                         taken_q
);
    localparam logic [31:0] EXCM_MASK = 32'h1 << PS_EXCM_BIT;
    localparam logic [31:0] LVL_MASK  = (32'h1 << PS_LVL_W) - 32'h1;

    // Commit all state for an accepted interrupt on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= '0;
            epc_q   <= '0;
            eps_q   <= '0;
            depc_q  <= '0;
            cause_q <= '0;
            pc_q    <= '0;
            cls_q   <= CLS_NONE;
            taken_q <= 1'b0;
        end else begin
            taken_q <= take;
            if (take) begin
                pc_q  <= target;
                cls_q <= cls;
                if (cls == CLS_HIGH) begin
                    for (int l = 2; l <= NUM_LEVELS; l++) begin
                        if (int'(level) == l) begin
                            epc_q[l-1] <= pc_cur;
                            eps_q[l-2] <= ps_cur;
                        end
                    end
                    ps_q <= (ps_cur & ~(LVL_MASK | EXCM_MASK)) | EXCM_MASK
                            | (32'(level) & LVL_MASK);
                end else begin
                    cause_q <= CAUSE_LEVEL1;
                    ps_q    <= ps_cur | EXCM_MASK;
                    if (cls == CLS_DOUBLE && HAS_DEPC) begin
                        depc_q <= pc_cur;
                    end else begin
                        epc_q[0] <= pc_cur;
                    end
                end
            end
        end
    end

    // Acceptance always leaves exception mode set.
    p_excm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> ps_q[PS_EXCM_BIT]);

    // A high-level acceptance installs the pending level as the new level.
    p_high_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_q && cls_q == CLS_HIGH) |-> (ps_q[3:0] == $past(level[3:0])));
endmodule

// File: rtl/irq_dispatch.sv
// Module: top of the interrupt dispatch unit.
// Decides acceptance, classifies level-1 interrupts into exception classes,
// selects the vector and commits saved state on one edge.
// Assumes 2 <= NUM_LEVELS <= 7 and ps_cur uses the idu_pkg PS layout.
module irq_dispatch
    import idu_pkg::*;
#(
    parameter int               NUM_LEVELS = 7,
    parameter int               NIRQ       = 16,
    parameter int               LVL_W      = 4,
    parameter bit               HAS_DEPC   = 1'b1,
    parameter logic [31:0]      DEF_BASE   = 32'h4000_0000,
    parameter logic [7:0][31:0] LVL_VEC    = {32'h4000_01E0, 32'h4000_01C0,
                                              32'h4000_01A0, 32'h4000_0180,
                                              32'h4000_0160, 32'h4000_0140,
                                              32'h4000_0120, 32'h4000_0100},
    parameter logic [31:0]      USER_VEC   = 32'h4000_0340,
    parameter logic [31:0]      KERNEL_VEC = 32'h4000_0300,
    parameter logic [31:0]      DOUBLE_VEC = 32'h4000_03C0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [LVL_W-1:0]             pend_level,
    input  logic [31:0]                  ps_cur,
    input  logic [NIRQ-1:0]              intset,
    input  logic [NIRQ-1:0]              intenable,
    input  logic [NUM_LEVELS*NIRQ-1:0]   level_mask,
    input  logic [31:0]                  pc_cur,
    input  logic [31:0]                  vecbase,
    input  logic                         reloc_en,
    output logic [31:0]                  ps_new,
    output logic [NUM_LEVELS*32-1:0]     epc_flat,
    output logic [(NUM_LEVELS-1)*32-1:0] eps_flat,
    output logic [31:0]                  depc,
    output logic [5:0]                   exccause,
    output logic [31:0]                  pc_next,
    output logic [2:0]                   exc_class,
    output logic                         taken
);
    logic                        take;
    exc_class_e                  cls_d;
    exc_class_e                  cls_q;
    logic [31:0]                 target;
    logic [NUM_LEVELS-1:0][31:0] epc_q;
    logic [NUM_LEVELS-2:0][31:0] eps_q;

    idu_gate #(.NUM_LEVELS(NUM_LEVELS), .NIRQ(NIRQ), .LVL_W(LVL_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_level (pend_level),
        .cur_level  (ps_cur[3:0]),
        .intset     (intset),
        .intenable  (intenable),
        .level_mask (level_mask),
        .take       (take)
    );

    // Classify: high levels vector directly, level 1 becomes an exception.
    always_comb begin
        if (pend_level > LVL_W'(1))     cls_d = CLS_HIGH;
        else if (ps_cur[PS_EXCM_BIT])   cls_d = CLS_DOUBLE;
        else if (ps_cur[PS_UM_BIT])     cls_d = CLS_USER;
        else                            cls_d = CLS_KERNEL;
    end

    idu_target #(
        .NUM_LEVELS (NUM_LEVELS), .LVL_W(LVL_W), .DEF_BASE(DEF_BASE),
        .LVL_VEC    (LVL_VEC), .USER_VEC(USER_VEC),
        .KERNEL_VEC (KERNEL_VEC), .DOUBLE_VEC(DOUBLE_VEC)
    ) u_target (
        .cls      (cls_d),
        .level    (pend_level),
        .vecbase  (vecbase),
        .reloc_en (reloc_en),
        .target   (target)
    );

    idu_state #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .HAS_DEPC(HAS_DEPC)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .cls     (cls_d),
        .level   (pend_level),
        .ps_cur  (ps_cur),
        .pc_cur  (pc_cur),
        .target  (target),
        .ps_q    (ps_new),
        .epc_q   (epc_q),
        .eps_q   (eps_q),
        .depc_q  (depc),
        .cause_q (exccause),
        .pc_q    (pc_next),
        .cls_q   (cls_q),
        .taken_q (taken)
    );

    assign epc_flat  = epc_q;
    assign eps_flat  = eps_q;
    assign exc_class = cls_q;

    // The strobe only follows an edge where the level beat the current one.
    p_taken_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (int'($past(pend_level)) > int'($past(ps_cur[3:0]))
                   && int'($past(pend_level)) <= NUM_LEVELS));

    // Without an acceptance, the visible state does not move.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> ($stable(pc_next) && $stable(ps_new) && $stable(exccause)
                    && $stable(exc_class) && $stable(depc)));

    // A double exception only arises when exception mode was already set.
    p_double_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class == 3'd4) |-> $past(ps_cur[PS_EXCM_BIT]));

    // Every level-1 acceptance reports the level-1 cause.
    p_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && exc_class != 3'd1) |-> (exccause == 6'd4));
endmodule

// File: tb/irq_dispatch_tb.sv
// Bench: behavioural reference model compared with the design on every cycle.
module irq_dispatch_tb;
    localparam int CLK_P = 10;
    localparam int NL    = 7;
    localparam int NI    = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [3:0]        pend_level;
    logic [31:0]       ps_cur, pc_cur, vecbase;
    logic [NI-1:0]     intset, intenable;
    logic [NL*NI-1:0]  level_mask;
    logic              reloc_en;

    logic [31:0]        ps_new, depc, pc_next;
    logic [NL*32-1:0]   epc_flat;
    logic [(NL-1)*32-1:0] eps_flat;
    logic [5:0]         exccause;
    logic [2:0]         exc_class;
    logic               taken;

    logic [31:0]        n_ps, n_depc, n_pc;
    logic [NL*32-1:0]   n_epc;
    logic [(NL-1)*32-1:0] n_eps;
    logic [5:0]         n_cause;
    logic [2:0]         n_cls;
    logic               n_taken;

    always #(CLK_P/2) clk = ~clk;

    irq_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .ps_cur(ps_cur),
        .intset(intset), .intenable(intenable), .level_mask(level_mask),
        .pc_cur(pc_cur), .vecbase(vecbase), .reloc_en(reloc_en),
        .ps_new(ps_new), .epc_flat(epc_flat), .eps_flat(eps_flat), .depc(depc),
        .exccause(exccause), .pc_next(pc_next), .exc_class(exc_class), .taken(taken)
    );

    irq_dispatch #(.HAS_DEPC(1'b0)) u_nd (
        .clk(clk), .rst_n(rst_n), .pend_level(pend_level), .ps_cur(ps_cur),
        .intset(intset), .intenable(intenable), .level_mask(level_mask),
        .pc_cur(pc_cur), .vecbase(vecbase), .reloc_en(reloc_en),
        .ps_new(n_ps), .epc_flat(n_epc), .eps_flat(n_eps), .depc(n_depc),
        .exccause(n_cause), .pc_next(n_pc), .exc_class(n_cls), .taken(n_taken)
    );

    // Reference model state.
    bit [31:0] e_ps, e_depc, e_pc, e_nd_depc, e_nd_epc1;
    bit [31:0] e_epc [1:7];
    bit [31:0] e_eps [2:7];
    int        e_cause, e_cls;
    bit        e_taken;

    int     n_compared = 0;
    int     n_mismatch = 0;
    string  cur_req = "R1";
    bit     run_done = 0;

    function automatic bit [31:0] lvl_vector(int l);
        return 32'h4000_0100 + 32'(l * 32'h20);
    endfunction

    // Model: one step of the dispatch rules per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_ps = 0; e_depc = 0; e_pc = 0; e_cause = 0; e_cls = 0; e_taken = 0;
            e_nd_depc = 0; e_nd_epc1 = 0;
            for (int i = 1; i <= 7; i++) e_epc[i] = 0;
            for (int i = 2; i <= 7; i++) e_eps[i] = 0;
        end else begin
            int lv;
            bit ok;
            bit [31:0] vec;
            lv = int'(pend_level);
            ok = (lv > int'(ps_cur[3:0])) && (lv <= NL) && (lv >= 1);
            if (ok) ok = ((level_mask[(lv-1)*NI +: NI] & intset & intenable) != 0);
            e_taken = ok;
            if (ok) begin
                if (lv > 1) begin
                    e_epc[lv] = pc_cur;
                    e_eps[lv] = ps_cur;
                    e_ps  = (ps_cur & ~32'h1F) | 32'h10 | 32'(lv);
                    e_cls = 1;
                    vec   = lvl_vector(lv);
                end else begin
                    e_cause = 4;
                    e_ps    = ps_cur | 32'h10;
                    if (ps_cur[4]) begin
                        e_cls = 4; vec = 32'h4000_03C0;
                        e_depc = pc_cur;
                        e_nd_epc1 = pc_cur;
                    end else begin
                        e_cls = ps_cur[5] ? 2 : 3;
                        vec   = ps_cur[5] ? 32'h4000_0340 : 32'h4000_0300;
                        e_epc[1]  = pc_cur;
                        e_nd_epc1 = pc_cur;
                    end
                end
                e_pc = reloc_en ? (vec - 32'h4000_0000 + vecbase) : vec;
            end
        end
    end

    task automatic chk(string fld, logic [31:0] act, logic [31:0] exp);
        n_compared++;
        if (act !== exp) begin
            n_mismatch++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, fld, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (!run_done) begin
            chk("taken", 32'(taken), 32'(e_taken));
            chk("ps_new", ps_new, e_ps);
            chk("pc_next", pc_next, e_pc);
            chk("depc", depc, e_depc);
            chk("exccause", 32'(exccause), 32'(e_cause));
            chk("exc_class", 32'(exc_class), 32'(e_cls));
            for (int i = 1; i <= 7; i++) chk($sformatf("epc%0d", i), epc_flat[(i-1)*32 +: 32], e_epc[i]);
            for (int i = 2; i <= 7; i++) chk($sformatf("eps%0d", i), eps_flat[(i-2)*32 +: 32], e_eps[i]);
            chk("nodepc_depc R11", n_depc, e_nd_depc);
            chk("nodepc_epc1 R11", n_epc[31:0], e_nd_epc1);
        end
    end

    // One qualifying-or-not stimulus cycle, then an idle cycle.
    task automatic apply(string req, int lv, bit [31:0] ps, bit [NI-1:0] set,
                         bit [NI-1:0] en, bit [31:0] pc, bit [31:0] vb, bit rel);
        @(negedge clk);
        #1;
        cur_req = req;
        pend_level = 4'(lv); ps_cur = ps; intset = set; intenable = en;
        pc_cur = pc; vecbase = vb; reloc_en = rel;
        @(negedge clk);
        #1;
        cur_req = {req, ",R3,R10"};
        pend_level = 0; intset = 0;
    endtask

    initial begin
        rst_n = 0; pend_level = 0; ps_cur = 0; intset = 0; intenable = 0;
        pc_cur = 0; vecbase = 0; reloc_en = 0;
        for (int l = 1; l <= NL; l++) level_mask[(l-1)*NI +: NI] = NI'(1) << l;
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1;
        apply("R4,R5", 3, 32'h0000_0001, 16'h0008, 16'hFFFF, 32'h1000_0010, 0, 0);
        apply("R4,R5", 7, 32'hABC0_0022, 16'h0080, 16'h0080, 32'h1000_0020, 0, 0);
        apply("R2,R10", 2, 32'h0000_0002, 16'h0004, 16'hFFFF, 32'h1000_0030, 0, 0);
        apply("R2,R10", 8, 32'h0000_0000, 16'hFFFF, 16'hFFFF, 32'h1000_0040, 0, 0);
        apply("R2,R10", 4, 32'h0000_0000, 16'h0010, 16'h0000, 32'h1000_0050, 0, 0);
        apply("R2,R10", 4, 32'h0000_0000, 16'h0008, 16'hFFFF, 32'h1000_0058, 0, 0);
        apply("R2", 0, 32'h0000_0000, 16'hFFFF, 16'hFFFF, 32'h1000_0060, 0, 0);
        apply("R6,R7", 1, 32'h0000_0000, 16'h0002, 16'h0002, 32'h1000_0070, 0, 0);
        apply("R6,R7", 1, 32'h0000_0020, 16'h0002, 16'h0002, 32'h1000_0080, 0, 0);
        apply("R8,R11", 1, 32'h0000_0010, 16'h0002, 16'h0002, 32'h1000_0090, 0, 0);
        apply("R9", 2, 32'h0000_0000, 16'h0004, 16'h0004, 32'h1000_00A0, 32'h8000_0000, 1);
        apply("R9", 1, 32'h0000_0000, 16'h0002, 16'h0002, 32'h1000_00B0, 32'h1230_0000, 1);
        apply("R9,R8", 1, 32'h0000_0030, 16'h0002, 16'h0002, 32'h1000_00C0, 32'h0000_4000, 1);
        for (int k = 0; k < 400; k++) begin
            apply("R2,R4,R7,R8,R9", int'($urandom_range(0, 8)),
                  {$urandom} & 32'hFFFF_FF3F | (32'($urandom_range(0, 3)) << 4),
                  NI'($urandom), NI'($urandom), $urandom, $urandom, 1'($urandom));
        end
        @(negedge clk);
        run_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatch);
        $finish;
    end

    // Watchdog: an unfinished run counts as a failed check.
    initial begin
        #(CLK_P * 50000);
        if (!run_done) begin
            run_done = 1;
            n_compared++;
            n_mismatch++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatch);
            $finish;
        end
    end
endmodule